// File: doc/BRIEF.md
# Reorder Buffer With Mispredict Recovery

This block keeps in-flight instructions in program order inside a circular buffer of `DEPTH` slots, where `DEPTH` is a power of two. At dispatch, the slot at the tail is claimed and its index goes back as the instruction's tag. The new slot records the destination register, whether the instruction is a store, its load/store queue slot, and the rename mapping it displaces. The rename table then points that register at the new tag.

Writeback uses the tag to mark a slot finished, to store its result, and to flag a data-TLB miss. When writeback reports a mispredicted branch, every entry younger than the branch is thrown away in one cycle. The branch itself stays. The discarded entries are visited from the newest back toward the branch, so each register rewritten by a discarded producer gets back the mapping the oldest such producer displaced.

Commit retires finished entries from the head, strictly in order, up to `CW` per cycle. Each retired result is written to the architected register file. A rename entry is released when it still names a retired tag. The head holds for a fixed number of cycles when it carries a TLB miss. A store at the head must have its write accepted by the data cache before it retires.

Top module: `rob_core`

## Requirements
- R1: Reset state (the internal reset releases two clock edges after `rst_n` rises): the buffer is empty and `disp_ready` is 1. Every register maps to the architected file (`map_rd_busy`=0) and reads zero. `cmt_valid` and `dc_store_req` are 0.
- R2: An accepted dispatch takes the slot whose index shows on `disp_tag`. Tags increase by one per dispatch and wrap modulo `DEPTH`. From the next cycle, a dispatch with a destination makes that register read busy with the new tag.
- R3: When all `DEPTH` slots are occupied, `disp_ready` is 0. A dispatch offered then changes neither the tail nor any mapping.
- R4: Only the oldest entry may retire, and only after its writeback. A finished younger entry waits behind an unfinished older one.
- R5: Up to `CW` consecutive finished entries from the head retire in one cycle. `cmt_valid` bit k marks lane k, where lane k is the entry k places behind the head, and the set bits always start at bit 0.
- R6: A retiring entry with a destination writes its result into the architected file. Its register's mapping returns to the architected file only if the mapping still names that entry's tag; a younger producer's mapping is kept.
- R7: A finished head entry with its TLB-miss flag set stalls for `TLB_LAT` cycles before it retires.
- R8: A finished store at the head raises `dc_store_req` with its queue slot on `dc_store_lsq`. It retires only in a cycle where `dc_store_ack` is 1. A store that is not at the head ends that cycle's retirement group before its own lane.
- R9: In the cycle an entry that owns a load/store queue slot retires, `lsq_free_valid` bit k goes high for its lane k, and the slot id appears in bits [k*LSQW +: LSQW] of `lsq_free_id`.
- R10: A mispredicted writeback on an unfinished live entry removes every younger entry, so none of them ever retires. The branch is kept, and the next dispatch gets tag branch+1.
- R11: After a squash, a register whose newest producer was squashed maps to whatever the oldest squashed producer of that register displaced. When that earlier owner has already retired, the register maps to the architected file.
- R12: In a cycle with a recovery, `disp_ready` is 0 and an offered dispatch is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_tag | output | TW | Tag the offered instruction receives |
| disp_has_dest | input | 1 | Instruction writes a register |
| disp_dest | input | RW | Destination register |
| disp_is_store | input | 1 | Instruction is a store |
| disp_has_lsq | input | 1 | Instruction owns a load/store queue slot |
| disp_lsq_id | input | LSQW | Load/store queue slot id |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | TW | Tag being finished |
| wb_data | input | DW | Result value |
| wb_mispred | input | 1 | Entry is a mispredicted branch |
| wb_tlb_miss | input | 1 | Entry missed in the data TLB |
| dc_store_req | output | 1 | Head store asks to write the data cache |
| dc_store_lsq | output | LSQW | Queue slot of the requesting store |
| dc_store_ack | input | 1 | Data cache accepts the store this cycle |
| cmt_valid | output | CW | Retire strobe per commit lane |
| lsq_free_valid | output | CW | Queue slot released per commit lane |
| lsq_free_id | output | CW*LSQW | Released slot ids, lane k in bits [k*LSQW +: LSQW] |
| map_rd_reg | input | RW | Rename table lookup register |
| map_rd_busy | output | 1 | Register is mapped to an in-flight tag |
| map_rd_tag | output | TW | Tag the register is mapped to |
| arf_rd_reg | input | RW | Architected file read register |
| arf_rd_data | output | DW | Architected file read value |

## Verification
The bench first finishes a younger entry ahead of its elder. A design that retired out of order would write the architected file early, and one that retired a whole finished window would let `cmt_valid` run past `CW` lanes. It then retires a register while a younger producer still owns its mapping; a rename clear keyed on the register number alone would release the wrong mapping. Other cases: a refused store, a store in the second lane, and a TLB-miss head whose stall is counted cycle by cycle. An off-by-one service counter or an unchecked acknowledge shows up as a retirement in the wrong cycle.

The last case recovers after a younger producer has already finished. A squash that kept the branch out, or left the tail past it, would hand out the wrong next tag or retire the squashed result. A restore that applied the newest displaced mapping instead of the oldest would leave a register pointing at a dead tag. A dispatch offered during recovery checks that it does not slip in.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int ROB_DEPTH_D = 8;
  localparam int ROB_NREG_D  = 16;
  localparam int ROB_DW_D    = 16;
  localparam int ROB_CW_D    = 2;
  localparam int ROB_TLB_D   = 3;
  localparam int ROB_LSQW_D  = 3;
endpackage

// File: rtl/rob_rename_map.sv
module rob_rename_map #(
  parameter int NREG  = 16,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          rs_vld,
  input  logic [NREG-1:0]          rs_busy,
  input  logic [$clog2(DEPTH)-1:0] rs_tag [NREG],
  input  logic [DEPTH-1:0]         survive,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_reg,
  input  logic [$clog2(DEPTH)-1:0] wr_tag,
  input  logic [$clog2(NREG)-1:0]  rd_reg,
  output logic                     rd_busy,
  output logic [$clog2(DEPTH)-1:0] rd_tag,
  input  logic [$clog2(NREG)-1:0]  pv_reg,
  output logic                     pv_busy,
  output logic [$clog2(DEPTH)-1:0] pv_tag
);
  localparam int TW = $clog2(DEPTH);

  logic [NREG-1:0] busy_q, busy_d;
  logic [TW-1:0]   tag_q [NREG];
  logic [TW-1:0]   tag_d [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      busy_d[r] = busy_q[r];
      tag_d[r]  = tag_q[r];
      if (rs_vld[r]) begin
        busy_d[r] = rs_busy[r];
        tag_d[r]  = rs_tag[r];
      end
      // a mapping naming a slot that leaves this cycle falls back to the file
      busy_d[r] = busy_d[r] & survive[tag_d[r]];
    end
    if (wr_en) begin
      busy_d[wr_reg] = 1'b1;
      tag_d[wr_reg]  = wr_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int r = 0; r < NREG; r++) tag_q[r] <= '0;
    end else begin
      busy_q <= busy_d;
      for (int r = 0; r < NREG; r++) tag_q[r] <= tag_d[r];
    end
  end

  assign rd_busy = busy_q[rd_reg];
  assign rd_tag  = tag_q[rd_reg];
  assign pv_busy = busy_q[pv_reg] & survive[tag_q[pv_reg]];
  assign pv_tag  = tag_q[pv_reg];

  assert_map_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (busy_q[$past(wr_reg)] && (tag_q[$past(wr_reg)] == $past(wr_tag))));
endmodule

// File: rtl/rob_arch_regs.sv
module rob_arch_regs #(
  parameter int NREG = 16,
  parameter int DW   = 16,
  parameter int CW   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CW-1:0]           wr_en,
  input  logic [$clog2(NREG)-1:0] wr_reg  [CW],
  input  logic [DW-1:0]           wr_data [CW],
  input  logic [$clog2(NREG)-1:0] rd_reg,
  output logic [DW-1:0]           rd_data
);
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++) regs_d[r] = regs_q[r];
    // later lanes are younger, so they are applied last
    for (int k = 0; k < CW; k++)
      if (wr_en[k]) regs_d[wr_reg[k]] = wr_data[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
    else        for (int r = 0; r < NREG; r++) regs_q[r] <= regs_d[r];
  end

  assign rd_data = regs_q[rd_reg];

  assert_youngest_lane_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[CW-1] |=> (regs_q[$past(wr_reg[CW-1])] == $past(wr_data[CW-1])));
endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl #(
  parameter int CW      = 2,
  parameter int TLB_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] lane_rdy,
  input  logic [CW-1:0] lane_st,
  input  logic [CW-1:0] lane_tlb,
  input  logic          dc_ack,
  output logic          dc_req,
  output logic [CW-1:0] retire
);
  localparam int CTW = (TLB_LAT < 1) ? 1 : $clog2(TLB_LAT + 1);

  logic [CTW-1:0] cnt_q, cnt_d;
  logic           tlb_ok;

  assign tlb_ok    = ~lane_tlb[0] | (cnt_q == CTW'(TLB_LAT));
  assign dc_req    = lane_rdy[0] & lane_st[0] & tlb_ok;
  assign retire[0] = lane_rdy[0] & tlb_ok & (~lane_st[0] | dc_ack);

  for (genvar k = 1; k < CW; k++) begin : g_lane
    assign retire[k] = retire[k-1] & lane_rdy[k] & ~lane_st[k] & ~lane_tlb[k];
  end

  always_comb begin
    cnt_d = cnt_q;
    if (retire[0])                                          cnt_d = '0;
    else if (lane_rdy[0] & lane_tlb[0] & ~tlb_ok)           cnt_d = cnt_q + CTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tlb_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= TLB_LAT);
  assert_tlb_served_before_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire[0] && lane_tlb[0]) |-> (int'(cnt_q) == TLB_LAT));
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH   = ROB_DEPTH_D,
  parameter int NREG    = ROB_NREG_D,
  parameter int DW      = ROB_DW_D,
  parameter int CW      = ROB_CW_D,
  parameter int TLB_LAT = ROB_TLB_D,
  parameter int LSQW    = ROB_LSQW_D
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  output logic                     disp_ready,
  output logic [$clog2(DEPTH)-1:0] disp_tag,
  input  logic                     disp_has_dest,
  input  logic [$clog2(NREG)-1:0]  disp_dest,
  input  logic                     disp_is_store,
  input  logic                     disp_has_lsq,
  input  logic [LSQW-1:0]          disp_lsq_id,
  input  logic                     wb_valid,
  input  logic [$clog2(DEPTH)-1:0] wb_tag,
  input  logic [DW-1:0]            wb_data,
  input  logic                     wb_mispred,
  input  logic                     wb_tlb_miss,
  output logic                     dc_store_req,
  output logic [LSQW-1:0]          dc_store_lsq,
  input  logic                     dc_store_ack,
  output logic [CW-1:0]            cmt_valid,
  output logic [CW-1:0]            lsq_free_valid,
  output logic [CW*LSQW-1:0]       lsq_free_id,
  input  logic [$clog2(NREG)-1:0]  map_rd_reg,
  output logic                     map_rd_busy,
  output logic [$clog2(DEPTH)-1:0] map_rd_tag,
  input  logic [$clog2(NREG)-1:0]  arf_rd_reg,
  output logic [DW-1:0]            arf_rd_data
);
  localparam int TW   = $clog2(DEPTH);
  localparam int RW   = $clog2(NREG);
  localparam int CNTW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic            vld;
    logic            done;
    logic            dst_en;
    logic [RW-1:0]   dst;
    logic            prv_busy;
    logic [TW-1:0]   prv_tag;
    logic            st;
    logic            tlb;
    logic            lsq_en;
    logic [LSQW-1:0] lsq;
    logic [DW-1:0]   data;
  } ent_t;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  ent_t            ent_q [DEPTH];
  ent_t            ent_d [DEPTH];
  logic [TW-1:0]   head_q, head_d, tail_q, tail_d;
  logic [CNTW-1:0] count_q, count_d, ncommit;

  logic            full, recover, disp_fire, wb_hit;
  logic [TW-1:0]   boff;
  logic [DEPTH-1:0] sq, retire_slot, survive;

  logic [TW-1:0]   lane_idx [CW];
  logic [CW-1:0]   lane_rdy, lane_st, lane_tlb, retire;
  logic [CW-1:0]   arf_we;
  logic [RW-1:0]   arf_wreg [CW];
  logic [DW-1:0]   arf_wdat [CW];

  logic [NREG-1:0] rs_vld, rs_busy;
  logic [TW-1:0]   rs_tag [NREG];
  logic            pv_busy;
  logic [TW-1:0]   pv_tag;

  assign full       = (count_q == CNTW'(DEPTH));
  assign recover    = wb_valid & wb_mispred & ent_q[wb_tag].vld & ~ent_q[wb_tag].done;
  assign disp_ready = ~full & ~recover;
  assign disp_fire  = disp_valid & disp_ready;
  assign disp_tag   = tail_q;
  assign boff       = wb_tag - head_q;

  for (genvar k = 0; k < CW; k++) begin : g_lane
    assign lane_idx[k] = head_q + TW'(k);
    assign lane_rdy[k] = ent_q[lane_idx[k]].vld & ent_q[lane_idx[k]].done;
    assign lane_st[k]  = ent_q[lane_idx[k]].st;
    assign lane_tlb[k] = ent_q[lane_idx[k]].tlb;
    assign arf_we[k]   = retire[k] & ent_q[lane_idx[k]].dst_en;
    assign arf_wreg[k] = ent_q[lane_idx[k]].dst;
    assign arf_wdat[k] = ent_q[lane_idx[k]].data;
    assign lsq_free_valid[k]          = retire[k] & ent_q[lane_idx[k]].lsq_en;
    assign lsq_free_id[k*LSQW +: LSQW] = ent_q[lane_idx[k]].lsq;
  end

  rob_commit_ctrl #(.CW(CW), .TLB_LAT(TLB_LAT)) u_commit (
    .clk(clk), .rst_n(rst_i_n), .lane_rdy(lane_rdy), .lane_st(lane_st),
    .lane_tlb(lane_tlb), .dc_ack(dc_store_ack), .dc_req(dc_store_req), .retire(retire)
  );
  assign cmt_valid    = retire;
  assign dc_store_lsq = ent_q[head_q].lsq;

  always_comb begin
    retire_slot = '0;
    ncommit     = '0;
    for (int k = 0; k < CW; k++) begin
      if (retire[k]) retire_slot[lane_idx[k]] = 1'b1;
      ncommit = ncommit + CNTW'(retire[k]);
    end
    for (int i = 0; i < DEPTH; i++) begin
      sq[i]      = recover & ent_q[i].vld & ((TW'(i) - head_q) > boff);
      survive[i] = ent_q[i].vld & ~sq[i] & ~retire_slot[i];
    end
  end

  // newest-to-oldest walk: the oldest squashed producer's saved mapping wins
  always_comb begin : p_restore
    logic [TW-1:0] ridx;
    rs_vld  = '0;
    rs_busy = '0;
    for (int r = 0; r < NREG; r++) rs_tag[r] = '0;
    for (int j = 0; j < DEPTH; j++) begin
      ridx = tail_q - TW'(1) - TW'(j);
      if (sq[ridx] && ent_q[ridx].dst_en) begin
        rs_vld[ent_q[ridx].dst]  = 1'b1;
        rs_busy[ent_q[ridx].dst] = ent_q[ridx].prv_busy;
        rs_tag[ent_q[ridx].dst]  = ent_q[ridx].prv_tag;
      end
    end
  end

  rob_rename_map #(.NREG(NREG), .DEPTH(DEPTH)) u_map (
    .clk(clk), .rst_n(rst_i_n), .rs_vld(rs_vld), .rs_busy(rs_busy), .rs_tag(rs_tag),
    .survive(survive), .wr_en(disp_fire & disp_has_dest), .wr_reg(disp_dest),
    .wr_tag(tail_q), .rd_reg(map_rd_reg), .rd_busy(map_rd_busy), .rd_tag(map_rd_tag),
    .pv_reg(disp_dest), .pv_busy(pv_busy), .pv_tag(pv_tag)
  );

  rob_arch_regs #(.NREG(NREG), .DW(DW), .CW(CW)) u_arf (
    .clk(clk), .rst_n(rst_i_n), .wr_en(arf_we), .wr_reg(arf_wreg), .wr_data(arf_wdat),
    .rd_reg(arf_rd_reg), .rd_data(arf_rd_data)
  );

  assign wb_hit = wb_valid & ent_q[wb_tag].vld & ~sq[wb_tag];

  always_comb begin
    ent_d = ent_q;
    for (int i = 0; i < DEPTH; i++)
      if (retire_slot[i] || sq[i]) ent_d[i].vld = 1'b0;
    if (wb_hit) begin
      ent_d[wb_tag].done = 1'b1;
      ent_d[wb_tag].data = wb_data;
      ent_d[wb_tag].tlb  = wb_tlb_miss;
    end
    if (disp_fire) begin
      ent_d[tail_q].vld      = 1'b1;
      ent_d[tail_q].done     = 1'b0;
      ent_d[tail_q].dst_en   = disp_has_dest;
      ent_d[tail_q].dst      = disp_dest;
      ent_d[tail_q].prv_busy = pv_busy;
      ent_d[tail_q].prv_tag  = pv_tag;
      ent_d[tail_q].st       = disp_is_store;
      ent_d[tail_q].tlb      = 1'b0;
      ent_d[tail_q].lsq_en   = disp_has_lsq;
      ent_d[tail_q].lsq      = disp_lsq_id;
      ent_d[tail_q].data     = '0;
    end
  end

  always_comb begin
    head_d = head_q + TW'(ncommit);
    if (recover) begin
      tail_d  = wb_tag + TW'(1);
      count_d = CNTW'(boff) + CNTW'(1) - ncommit;
    end else begin
      tail_d  = tail_q + TW'(disp_fire);
      count_d = count_q + CNTW'(disp_fire) - ncommit;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    count_q <= CNTW'(DEPTH));
  assert_store_refused_holds_head_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dc_store_req && !dc_store_ack) |=> (head_q == $past(head_q)));
  assert_tail_rewinds_to_branch_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    recover |=> (tail_q == $past(wb_tag) + TW'(1)));
  assert_empty_no_retire_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (count_q == '0) |-> (cmt_valid == '0));
endmodule

// File: tb/rob_core_bench.sv
module rob_core_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       disp_valid, disp_ready, disp_has_dest, disp_is_store, disp_has_lsq;
  logic [2:0] disp_tag, disp_lsq_id;
  logic [3:0] disp_dest;
  logic       wb_valid, wb_mispred, wb_tlb_miss;
  logic [2:0] wb_tag;
  logic [15:0] wb_data;
  logic       dc_store_req, dc_store_ack;
  logic [2:0] dc_store_lsq;
  logic [1:0] cmt_valid, lsq_free_valid;
  logic [5:0] lsq_free_id;
  logic [3:0] map_rd_reg, arf_rd_reg;
  logic       map_rd_busy;
  logic [2:0] map_rd_tag;
  logic [15:0] arf_rd_data;

  int checks = 0;
  int failures = 0;
  logic [2:0] exp_tail = 3'd0;

  always #10 clk = ~clk;

  rob_core u_rob_core (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_tag(disp_tag), .disp_has_dest(disp_has_dest), .disp_dest(disp_dest),
    .disp_is_store(disp_is_store), .disp_has_lsq(disp_has_lsq), .disp_lsq_id(disp_lsq_id),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_mispred(wb_mispred),
    .wb_tlb_miss(wb_tlb_miss), .dc_store_req(dc_store_req), .dc_store_lsq(dc_store_lsq),
    .dc_store_ack(dc_store_ack), .cmt_valid(cmt_valid), .lsq_free_valid(lsq_free_valid),
    .lsq_free_id(lsq_free_id), .map_rd_reg(map_rd_reg), .map_rd_busy(map_rd_busy),
    .map_rd_tag(map_rd_tag), .arf_rd_reg(arf_rd_reg), .arf_rd_data(arf_rd_data)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic map_is(input string req, input logic [3:0] r, input logic busy, input logic [2:0] tag);
    map_rd_reg = r;
    #1;
    check({req, " map busy"}, {31'd0, map_rd_busy}, {31'd0, busy});
    if (busy) check({req, " map tag"}, {29'd0, map_rd_tag}, {29'd0, tag});
  endtask

  task automatic arf_is(input string req, input logic [3:0] r, input logic [15:0] v);
    arf_rd_reg = r;
    #1;
    check({req, " arf"}, {16'd0, arf_rd_data}, {16'd0, v});
  endtask

  task automatic disp(input logic hd, input logic [3:0] d, input logic st, input logic le, input logic [2:0] lid);
    disp_valid = 1'b1; disp_has_dest = hd; disp_dest = d;
    disp_is_store = st; disp_has_lsq = le; disp_lsq_id = lid;
    #1;
    check("R2 tag", {29'd0, disp_tag}, {29'd0, exp_tail});
    tick();
    disp_valid = 1'b0;
    exp_tail = exp_tail + 3'd1;
  endtask

  task automatic wb(input logic [2:0] t, input logic [15:0] d, input logic mp, input logic tm);
    wb_valid = 1'b1; wb_tag = t; wb_data = d; wb_mispred = mp; wb_tlb_miss = tm;
    tick();
    wb_valid = 1'b0; wb_mispred = 1'b0; wb_tlb_miss = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    check("R1 ready", {31'd0, disp_ready}, 32'd1);
    check("R1 cmt", {30'd0, cmt_valid}, 32'd0);
    check("R1 dcreq", {31'd0, dc_store_req}, 32'd0);
    map_is("R1", 4'd5, 1'b0, 3'd0);
    arf_is("R1", 4'd5, 16'h0);
  endtask

  task automatic t_order();
    disp(1'b1, 4'd1, 1'b0, 1'b0, 3'd0);
    disp(1'b1, 4'd2, 1'b0, 1'b0, 3'd0);
    disp(1'b1, 4'd1, 1'b0, 1'b0, 3'd0);
    map_is("R2", 4'd1, 1'b1, 3'd2);
    map_is("R2", 4'd2, 1'b1, 3'd1);
    wb(3'd1, 16'h0022, 1'b0, 1'b0);
    check("R4 younger waits", {30'd0, cmt_valid}, 32'd0);
    tick();
    check("R4 still waits", {30'd0, cmt_valid}, 32'd0);
    wb(3'd0, 16'h0011, 1'b0, 1'b0);
    check("R5 two lanes", {30'd0, cmt_valid}, 32'd3);
    tick();
    arf_is("R6 r1", 4'd1, 16'h0011);
    arf_is("R6 r2", 4'd2, 16'h0022);
    map_is("R6 cleared", 4'd2, 1'b0, 3'd0);
    map_is("R6 younger kept", 4'd1, 1'b1, 3'd2);
    wb(3'd2, 16'h0033, 1'b0, 1'b0);
    check("R4 head", {30'd0, cmt_valid}, 32'd1);
    tick();
    arf_is("R6 r1 new", 4'd1, 16'h0033);
    map_is("R6 r1 freed", 4'd1, 1'b0, 3'd0);
  endtask

  task automatic t_width();
    disp(1'b0, 4'd0, 1'b0, 1'b0, 3'd0);
    disp(1'b0, 4'd0, 1'b0, 1'b0, 3'd0);
    disp(1'b0, 4'd0, 1'b0, 1'b0, 3'd0);
    wb(3'd5, 16'h1, 1'b0, 1'b0);
    wb(3'd4, 16'h1, 1'b0, 1'b0);
    check("R4 none before head", {30'd0, cmt_valid}, 32'd0);
    wb(3'd3, 16'h1, 1'b0, 1'b0);
    check("R5 capped", {30'd0, cmt_valid}, 32'd3);
    tick();
    check("R5 remainder", {30'd0, cmt_valid}, 32'd1);
    tick();
    check("R5 drained", {30'd0, cmt_valid}, 32'd0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) disp(1'b0, 4'd0, 1'b0, 1'b0, 3'd0);
    #1;
    check("R3 ready low", {31'd0, disp_ready}, 32'd0);
    disp_valid = 1'b1; disp_has_dest = 1'b1; disp_dest = 4'd7;
    tick();
    disp_valid = 1'b0;
    map_is("R3 ignored", 4'd7, 1'b0, 3'd0);
    check("R3 tail held", {29'd0, disp_tag}, {29'd0, exp_tail});
    for (int i = 0; i < 8; i++) wb(3'(6 + i), 16'h2, 1'b0, 1'b0);
    tick(); tick();
    check("R3 ready again", {31'd0, disp_ready}, 32'd1);
  endtask

  task automatic t_tlb();
    disp(1'b1, 4'd3, 1'b0, 1'b0, 3'd0);
    wb(3'd6, 16'h0055, 1'b0, 1'b1);
    for (int c = 0; c < 3; c++) begin
      check("R7 stall", {30'd0, cmt_valid}, 32'd0);
      tick();
    end
    check("R7 retire", {30'd0, cmt_valid}, 32'd1);
    tick();
    arf_is("R7 written", 4'd3, 16'h0055);
  endtask

  task automatic t_store();
    dc_store_ack = 1'b0;
    disp(1'b0, 4'd0, 1'b1, 1'b1, 3'd5);
    wb(3'd7, 16'h0, 1'b0, 1'b0);
    check("R8 req", {31'd0, dc_store_req}, 32'd1);
    check("R8 lsq", {29'd0, dc_store_lsq}, 32'd5);
    check("R8 refused", {30'd0, cmt_valid}, 32'd0);
    tick();
    check("R8 still held", {30'd0, cmt_valid}, 32'd0);
    check("R9 no free", {30'd0, lsq_free_valid}, 32'd0);
    dc_store_ack = 1'b1;
    #1;
    check("R8 accepted", {30'd0, cmt_valid}, 32'd1);
    check("R9 free", {30'd0, lsq_free_valid}, 32'd1);
    check("R9 id", {29'd0, lsq_free_id[2:0]}, 32'd5);
    tick();
    dc_store_ack = 1'b0;
    disp(1'b1, 4'd8, 1'b0, 1'b0, 3'd0);
    disp(1'b0, 4'd0, 1'b1, 1'b1, 3'd2);
    wb(3'd1, 16'h0, 1'b0, 1'b0);
    wb(3'd0, 16'h0088, 1'b0, 1'b0);
    check("R8 lane1 store blocks", {30'd0, cmt_valid}, 32'd1);
    check("R8 no req off head", {31'd0, dc_store_req}, 32'd0);
    tick();
    dc_store_ack = 1'b1;
    #1;
    check("R8 head store", {30'd0, cmt_valid}, 32'd1);
    check("R9 id lane0", {29'd0, lsq_free_id[2:0]}, 32'd2);
    tick();
    dc_store_ack = 1'b0;
    arf_is("R6 r8", 4'd8, 16'h0088);
  endtask

  task automatic t_squash();
    disp(1'b1, 4'd4, 1'b0, 1'b0, 3'd0);
    disp(1'b0, 4'd0, 1'b0, 1'b0, 3'd0);
    disp(1'b1, 4'd4, 1'b0, 1'b0, 3'd0);
    disp(1'b1, 4'd5, 1'b0, 1'b0, 3'd0);
    wb(3'd5, 16'h0099, 1'b0, 1'b0);
    map_is("R2 r4", 4'd4, 1'b1, 3'd4);
    wb_valid = 1'b1; wb_tag = 3'd3; wb_data = 16'h0; wb_mispred = 1'b1;
    disp_valid = 1'b1; disp_has_dest = 1'b1; disp_dest = 4'd6;
    disp_is_store = 1'b0; disp_has_lsq = 1'b0;
    #1;
    check("R12 ready low", {31'd0, disp_ready}, 32'd0);
    tick();
    wb_valid = 1'b0; wb_mispred = 1'b0; disp_valid = 1'b0;
    map_is("R12 not taken", 4'd6, 1'b0, 3'd0);
    map_is("R11 restore", 4'd4, 1'b1, 3'd2);
    map_is("R11 to file", 4'd5, 1'b0, 3'd0);
    check("R10 next tag", {29'd0, disp_tag}, 32'd4);
    wb(3'd2, 16'h0044, 1'b0, 1'b0);
    check("R10 branch kept", {30'd0, cmt_valid}, 32'd3);
    tick();
    check("R10 squashed gone", {30'd0, cmt_valid}, 32'd0);
    arf_is("R10 r4", 4'd4, 16'h0044);
    arf_is("R10 r5 untouched", 4'd5, 16'h0);
    map_is("R6 r4 free", 4'd4, 1'b0, 3'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    disp_valid = 1'b0; disp_has_dest = 1'b0; disp_dest = '0; disp_is_store = 1'b0;
    disp_has_lsq = 1'b0; disp_lsq_id = '0;
    wb_valid = 1'b0; wb_tag = '0; wb_data = '0; wb_mispred = 1'b0; wb_tlb_miss = 1'b0;
    dc_store_ack = 1'b0; map_rd_reg = '0; arf_rd_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_order();
    t_width();
    t_full();
    t_tlb();
    t_store();
    t_squash();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule